// File: doc/BRIEF.md
# E1 Receive Error Counter Bank

This block gathers performance-monitoring counts for an E1 receiver. Upstream framing and line logic send single-cycle strobes for six kinds of event: a frame alignment word received with a bit error, an E-bit error, a bipolar violation, a CRC-4 error, a PRBS test-pattern bit error and a received CRC multiframe. Each event has its own wrapping counter. A processor reads each counter as one or two byte-wide registers over a simple read/write bus.

When a counter wraps from all ones to zero, the block always sets a sticky overflow latch bit. It sets an overflow interrupt bit only if the mask bit for that counter allows it. Reading the latch register or the interrupt register returns its contents and clears it. A single interrupt line is driven from the unmasked interrupt bits. When software writes the PRBS error counter, the multiframe counter that goes with it is cleared, so a fresh error-rate measurement window starts.

Top module: `e1_err_counter_bank`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0x00 and `irq_o` is low.
- R2: The errored-alignment counter is 8 bits wide and is read at address 0. It adds one on each cycle in which `fas_err_i` is high, and it wraps from 0xFF to 0x00.
- R3: The E-bit and CRC-4 error counters are 10 bits wide and wrap from 0x3FF to 0. The E-bit counter's top 2 bits are read at address 1 and its low 8 bits at address 2. The CRC-4 counter's top 2 bits are read at address 5 and its low 8 bits at address 6. In the top-bits registers, bits 7:2 read 0.
- R4: The bipolar-violation counter is 16 bits wide and wraps from 0xFFFF to 0. Its high byte is read at address 3 and its low byte at address 4.
- R5: The PRBS error counter (address 7) and the multiframe counter (address 8) are each 8 bits wide. They add one per `prbs_err_i` strobe and per `crc_mfrm_i` strobe respectively.
- R6: A write to address 7 loads `wdata_i` into the PRBS error counter and clears the multiframe counter, both taking effect on the next cycle. The write takes priority over a strobe in the same cycle.
- R7: Writes to addresses 0 to 6 and 8 to 10 have no effect on any register.
- R8: A counter wrap from all ones to zero sets that counter's bit in the overflow latch (address 9), whatever the mask holds. The bit order is: 0 errored alignment, 1 E-bit, 2 bipolar violation, 3 CRC-4, 4 PRBS error, 5 multiframe.
- R9: A wrap sets the same bit in the interrupt register (address 10) only when that bit of the mask register (address 11) is 1. A mask bit of 1 means unmasked.
- R10: A read of address 9 or 10 returns the current value and then clears that register. A wrap in the same cycle as the read leaves its bit set afterwards.
- R11: `irq_o` is high exactly when some interrupt bit and its mask bit are both 1.
- R12: The mask register can be written and read back at address 11. Bits 7:6 of addresses 9, 10 and 11 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fas_err_i | input | 1 | Errored frame alignment word strobe |
| ebit_err_i | input | 1 | E-bit error strobe |
| bpv_i | input | 1 | Bipolar violation strobe |
| crc_err_i | input | 1 | CRC-4 error strobe |
| prbs_err_i | input | 1 | PRBS bit error strobe |
| crc_mfrm_i | input | 1 | Received CRC multiframe strobe |
| rd_en_i | input | 1 | Register read; clears the latch or interrupt register when addressed |
| wr_en_i | input | 1 | Register write |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from `addr_i` |
| irq_o | output | 1 | Combined interrupt, active high |

## Verification
The assertions check on every cycle that each counter is stable without a strobe, steps by exactly one on a strobe, and lands on zero after a wrap. They also check that a set request always leaves its flag bit high, that a read with no new event empties the register, that the PRBS write clears the multiframe counter, and that a fully masked bank never raises the interrupt. Only the bench scenarios can show the address map and byte split, the bit order of the latch and interrupt registers, the difference between latch and interrupt under a mask, and a wrap landing in the same cycle as the read that clears it.

// File: rtl/e1pm_pkg.sv
// Shared constants for the E1 error counter bank: register addresses and
// counter indices. Assumes at most 16-bit counters (two byte registers).
package e1pm_pkg;
    localparam int NCNT = 6;    // number of event counters
    localparam int MAXW = 16;   // widest counter the read mux supports
    localparam int AW   = 4;    // register address width
    localparam int DW   = 8;    // register data width

    // Counter indices; also the bit positions in latch/interrupt/mask regs
    localparam int CI_FAS  = 0;
    localparam int CI_EBIT = 1;
    localparam int CI_BPV  = 2;
    localparam int CI_CRC  = 3;
    localparam int CI_PRBS = 4;
    localparam int CI_MFRM = 5;

    typedef enum logic [AW-1:0] {
        RA_FAS     = 4'd0,
        RA_EBIT_HI = 4'd1,
        RA_EBIT_LO = 4'd2,
        RA_BPV_HI  = 4'd3,
        RA_BPV_LO  = 4'd4,
        RA_CRC_HI  = 4'd5,
        RA_CRC_LO  = 4'd6,
        RA_PRBS    = 4'd7,
        RA_MFRM    = 4'd8,
        RA_OVL     = 4'd9,
        RA_INT     = 4'd10,
        RA_MASK    = 4'd11
    } reg_addr_e;
endpackage

// File: rtl/e1pm_counter.sv
// Wrapping event counter with a synchronous load.
// Assumes: the increment strobe is one cycle per event; load beats increment.
// `wrap_o` is high in the cycle whose clock edge takes the count from all
// ones to zero.
module e1pm_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic         ld_i,
    input  logic [W-1:0] ld_val_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    // Flag a wrap when an unloaded increment hits the all-ones value
    always_comb wrap_o = inc_i && !ld_i && (&cnt_o);

    // Count register: reset, load, or increment
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_o <= '0;
        else if (ld_i)   cnt_o <= ld_val_i;
        else if (inc_i)  cnt_o <= cnt_o + 1'b1;
    end

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !ld_i) |=> $stable(cnt_o));
    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !ld_i) |=> (cnt_o == W'($past(cnt_o) + 1'b1)));
    // R8
    cnt_wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_o == '0));
endmodule

// File: rtl/e1pm_sticky.sv
// Bank of sticky flag bits. A set request wins over a clear-on-read in the
// same cycle. Assumes `rd_clr_i` is a single-cycle read strobe.
module e1pm_sticky #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         rd_clr_i,
    output logic [N-1:0] flags_o
);
    // Clear on read, then OR in new events
    always_ff @(posedge clk) begin
        if (!rst_n) flags_o <= '0;
        else        flags_o <= (rd_clr_i ? '0 : flags_o) | set_i;
    end

    // R10
    sticky_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((flags_o & $past(set_i)) == $past(set_i)));
    // R10
    sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && !(|set_i)) |=> (flags_o == '0));
    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_clr_i && !(|set_i)) |=> $stable(flags_o));
endmodule

// File: rtl/e1pm_regmux.sv
// Read data multiplexer. It splits each counter into byte registers and
// zero-fills bits the counter does not have. Purely combinational.
module e1pm_regmux
    import e1pm_pkg::*;
(
    input  logic [NCNT-1:0][MAXW-1:0] cnt_i,
    input  logic [NCNT-1:0]           ovl_i,
    input  logic [NCNT-1:0]           int_i,
    input  logic [NCNT-1:0]           mask_i,
    input  logic [AW-1:0]             addr_i,
    output logic [DW-1:0]             rdata_o
);
    localparam int PAD = DW - NCNT;

    // Select the byte addressed by the processor
    always_comb begin
        unique case (addr_i)
            RA_FAS:     rdata_o = cnt_i[CI_FAS][7:0];
            RA_EBIT_HI: rdata_o = cnt_i[CI_EBIT][15:8];
            RA_EBIT_LO: rdata_o = cnt_i[CI_EBIT][7:0];
            RA_BPV_HI:  rdata_o = cnt_i[CI_BPV][15:8];
            RA_BPV_LO:  rdata_o = cnt_i[CI_BPV][7:0];
            RA_CRC_HI:  rdata_o = cnt_i[CI_CRC][15:8];
            RA_CRC_LO:  rdata_o = cnt_i[CI_CRC][7:0];
            RA_PRBS:    rdata_o = cnt_i[CI_PRBS][7:0];
            RA_MFRM:    rdata_o = cnt_i[CI_MFRM][7:0];
            RA_OVL:     rdata_o = {{PAD{1'b0}}, ovl_i};
            RA_INT:     rdata_o = {{PAD{1'b0}}, int_i};
            RA_MASK:    rdata_o = {{PAD{1'b0}}, mask_i};
            default:    rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/e1_err_counter_bank.sv
// E1 receive error counter bank. Six wrapping event counters, overflow
// latch and maskable overflow interrupt bits, both clearing on read.
// Assumes single-cycle event strobes and single-cycle bus read/write strobes.
module e1_err_counter_bank
    import e1pm_pkg::*;
#(
    parameter int FAS_W  = 8,
    parameter int EBIT_W = 10,
    parameter int BPV_W  = 16,
    parameter int CRC_W  = 10,
    parameter int PRBS_W = 8,
    parameter int MFRM_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fas_err_i,
    input  logic          ebit_err_i,
    input  logic          bpv_i,
    input  logic          crc_err_i,
    input  logic          prbs_err_i,
    input  logic          crc_mfrm_i,
    input  logic          rd_en_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          irq_o
);
    logic [NCNT-1:0]           strobe;
    logic [NCNT-1:0]           wraps;
    logic [NCNT-1:0][MAXW-1:0] cnt_all;
    logic [NCNT-1:0]           ovl_q;
    logic [NCNT-1:0]           int_q;
    logic [NCNT-1:0]           mask_q;
    logic                      wr_prbs;
    logic                      wr_mask;
    logic                      rd_ovl;
    logic                      rd_int;

    // Gather event strobes in register bit order
    always_comb strobe = {crc_mfrm_i, prbs_err_i, crc_err_i, bpv_i, ebit_err_i, fas_err_i};

    // Bus decode
    always_comb begin
        wr_prbs = wr_en_i && (addr_i == RA_PRBS);
        wr_mask = wr_en_i && (addr_i == RA_MASK);
        rd_ovl  = rd_en_i && (addr_i == RA_OVL);
        rd_int  = rd_en_i && (addr_i == RA_INT);
    end

    // One counter per event, width picked per index
    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        localparam int W = (g == CI_FAS)  ? FAS_W  :
                           (g == CI_EBIT) ? EBIT_W :
                           (g == CI_BPV)  ? BPV_W  :
                           (g == CI_CRC)  ? CRC_W  :
                           (g == CI_PRBS) ? PRBS_W : MFRM_W;
        logic [W-1:0] val;
        logic         ld;
        logic [W-1:0] ld_val;

        // PRBS counter takes the written value, its multiframe partner clears
        always_comb begin
            ld     = ((g == CI_PRBS) || (g == CI_MFRM)) && wr_prbs;
            ld_val = (g == CI_PRBS) ? W'(wdata_i) : '0;
        end

        e1pm_counter #(.W(W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .inc_i    (strobe[g]),
            .ld_i     (ld),
            .ld_val_i (ld_val),
            .cnt_o    (val),
            .wrap_o   (wraps[g])
        );

        // Zero-extend to the common read width
        always_comb cnt_all[g] = MAXW'(val);
    end

    // Interrupt mask register, 1 = unmasked
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= wdata_i[NCNT-1:0];
    end

    e1pm_sticky #(.N(NCNT)) u_ovl (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (wraps),
        .rd_clr_i (rd_ovl),
        .flags_o  (ovl_q)
    );

    e1pm_sticky #(.N(NCNT)) u_int (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (wraps & mask_q),
        .rd_clr_i (rd_int),
        .flags_o  (int_q)
    );

    // Combined interrupt from unmasked bits
    always_comb irq_o = |(int_q & mask_q);

    e1pm_regmux u_mux (
        .cnt_i   (cnt_all),
        .ovl_i   (ovl_q),
        .int_i   (int_q),
        .mask_i  (mask_q),
        .addr_i  (addr_i),
        .rdata_o (rdata_o)
    );

    // R11
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_o);
    // R6
    mfrm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_prbs |=> (cnt_all[CI_MFRM] == '0));
    // R6
    prbs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_prbs |=> (cnt_all[CI_PRBS][7:0] == $past(wdata_i)));
    // R9
    int_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_int && (|(wraps & ~mask_q))) |=> ((int_q & ~$past(int_q) & ~$past(mask_q)) == '0));
endmodule

// File: tb/sim_e1_err_counter_bank.sv
`timescale 1ns/1ps
module sim_e1_err_counter_bank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] stb = '0;
    logic       rd_en = 1'b0, wr_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_cnt [6];
    int m_w   [6] = '{8, 10, 16, 10, 8, 8};
    int m_lat = 0, m_int = 0, m_mask = 0;

    always #2 clk = ~clk;

    e1_err_counter_bank u0 (
        .clk(clk), .rst_n(rst_n),
        .fas_err_i(stb[0]), .ebit_err_i(stb[1]), .bpv_i(stb[2]),
        .crc_err_i(stb[3]), .prbs_err_i(stb[4]), .crc_mfrm_i(stb[5]),
        .rd_en_i(rd_en), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq)
    );

    function automatic int exp_read(input int a);
        case (a)
            0: return m_cnt[0] & 8'hFF;
            1: return m_cnt[1] >> 8;
            2: return m_cnt[1] & 8'hFF;
            3: return m_cnt[2] >> 8;
            4: return m_cnt[2] & 8'hFF;
            5: return m_cnt[3] >> 8;
            6: return m_cnt[3] & 8'hFF;
            7: return m_cnt[4];
            8: return m_cnt[5];
            9: return m_lat;
            10: return m_int;
            11: return m_mask;
            default: return 0;
        endcase
    endfunction

    function automatic string req_of(input int a);
        case (a)
            0: return "R2";
            1, 2, 5, 6: return "R3";
            3, 4: return "R4";
            7, 8: return "R5";
            9: return "R8";
            10: return "R9";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One bus/strobe cycle: drive, check combinational outputs, advance model
    task automatic step(input logic [5:0] s, input logic rd, input logic wr,
                        input logic [3:0] a, input logic [7:0] wd);
        int wr_bits;
        @(negedge clk);
        stb = s; rd_en = rd; wr_en = wr; addr = a; wdata = wd;
        #1;
        check("R11", int'(irq), int'((m_int & m_mask) != 0));
        if (rd) check(req_of(a), int'(rdata), exp_read(a));
        wr_bits = 0;
        for (int i = 0; i < 6; i++) begin
            bit ld;
            ld = wr && (a == 4'd7) && (i >= 4);
            if (ld) m_cnt[i] = (i == 4) ? int'(wd) : 0;
            else if (s[i]) begin
                if (m_cnt[i] == (1 << m_w[i]) - 1) begin
                    m_cnt[i] = 0;
                    wr_bits |= (1 << i);
                end else m_cnt[i]++;
            end
        end
        m_lat = ((rd && a == 4'd9) ? 0 : m_lat) | wr_bits;
        m_int = ((rd && a == 4'd10) ? 0 : m_int) | (wr_bits & m_mask);
        if (wr && a == 4'd11) m_mask = wd & 8'h3F;
    endtask

    task automatic idle(); step(6'd0, 0, 0, 4'd0, 8'd0); endtask
    task automatic rd(input int a); step(6'd0, 1, 0, 4'(a), 8'd0); endtask
    task automatic wr(input int a, input int d); step(6'd0, 0, 1, 4'(a), 8'(d)); endtask
    task automatic pulse(input int idx, input int n);
        for (int k = 0; k < n; k++) step(6'(1 << idx), 0, 0, 4'd0, 8'd0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 6; i++) m_cnt[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        for (int a = 0; a < 12; a++) begin
            @(negedge clk); addr = 4'(a); #1;
            check("R1", int'(rdata), 0);
        end
        check("R1", int'(irq), 0);

        // R2 + R8: FAS wrap with mask clear sets latch only
        pulse(0, 255); rd(0);
        pulse(0, 1); rd(0);
        rd(9); rd(10);                 // R8 latch bit0, R9 int stays 0
        rd(9);                         // R10 cleared after read

        // R12 / R9: unmask all, check readback
        wr(11, 8'hFF); rd(11);
        // R3: E-bit wrap, R9 interrupt set, irq high
        pulse(1, 700); rd(1); rd(2);
        pulse(1, 323); rd(1); rd(2);
        // R10: wrap coincident with read of interrupt register
        step(6'b000010, 1, 0, 4'd10, 8'd0);
        rd(10); rd(10); rd(9);
        // R3: CRC-4 counter byte split
        pulse(3, 517); rd(5); rd(6);
        // R7: writes to counters/latches ignored
        for (int a = 0; a < 11; a++) if (a != 7) wr(a, 8'hA5);
        for (int a = 0; a < 11; a++) rd(a);
        // R5/R6: PRBS and multiframe
        pulse(4, 10); pulse(5, 20); rd(7); rd(8);
        step(6'b110000, 0, 1, 4'd7, 8'hFE);  // R6 load wins over strobes
        rd(7); rd(8);
        pulse(4, 2); rd(7); rd(9); rd(10);
        // R11: masking a pending interrupt drops irq
        pulse(5, 256); idle();
        wr(11, 8'h1F); idle(); wr(11, 8'h3F); rd(10);
        // R4: bipolar violation full wrap
        pulse(2, 300); rd(3); rd(4);
        pulse(2, 65236); rd(3); rd(4); rd(9);

        // Constrained random traffic
        for (int n = 0; n < 6000; n++) begin
            logic [5:0] s;
            int r, a;
            s = 6'($urandom) & 6'($urandom);
            r = $urandom_range(0, 9);
            a = $urandom_range(0, 12);
            if (r < 3) step(s, 1, 0, 4'(a), 8'd0);
            else if (r == 3) step(s, 0, 1, 4'(a), 8'($urandom));
            else step(s, 0, 0, 4'(a), 8'd0);
        end
        for (int a = 0; a < 13; a++) rd(a);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule